// File: doc/BRIEF.md
# One-Hot Output Enable Guard

This block sits between a four-position selector switch and four output stages that share one output connector. The switch contacts are untrusted: a failed switch may close several positions at once, and two output stages enabled together for a long time would fight each other. The guard turns the raw switch lines into four enable lines of which at most one is ever high. The switch lines are passed through a synchronizer, resolved, and then registered. Debouncing is left to the switch path.

Two resolution policies are selectable. In priority mode the highest-numbered active line wins. Its number is produced as a binary channel index, and that index is decoded back into a single enable. In lockout mode a lone active line is passed through, but any overlap of two or more lines drops every enable. In both modes a fault flag reports the overlap. A global allow input forces all enables low. Brief overlaps during a normal change of position are acceptable, so the block does no break-before-make sequencing.

Top module: `oen_guard`

## Requirements
- R1: While the synchronous reset `rst` is high, every clock edge clears `en_out`, `chan_idx`, `valid`, `fault` and the synchronizer stages to zero.
- R2: At most one bit of `en_out` is 1 in every cycle.
- R3: With `mode`=0 (priority) and `allow`=1, when any selector line is active, only `en_out[k]` is 1, where k is the highest active line index (line 3 is highest, line 0 lowest). `chan_idx`=k and `valid`=1.
- R4: With `mode`=1 (lockout) and `allow`=1, when exactly one selector line k is active, `en_out[k]`=1, `chan_idx`=k and `valid`=1.
- R5: With `mode`=1, when two or more selector lines are active, `en_out` is all zero, `valid`=0 and `chan_idx`=0.
- R6: `fault` is 1 exactly when two or more synchronized selector lines are active. This holds in both modes and regardless of `allow`.
- R7: With `allow`=0, `en_out` is all zero, `valid`=0 and `chan_idx`=0. `fault` is unaffected.
- R8: With no selector line active, `en_out` is zero, `valid`=0 and `chan_idx`=0.
- R9: A change on `sel_raw` reaches the outputs at the third rising edge after it, which is SYNC_STAGES plus one edges. `allow` and `mode` are synchronous inputs, and a change on them takes effect at the next rising edge.
- R10: `valid` is 1 exactly when `en_out` is nonzero. When `valid` is 1, `en_out[chan_idx]` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sel_raw | input | 4 | Raw selector switch lines, asynchronous, active high |
| allow | input | 1 | Global enable; 0 forces every enable low |
| mode | input | 1 | 0 = priority resolution, 1 = lockout on overlap |
| en_out | output | 4 | Registered output-stage enables, at most one high |
| chan_idx | output | 2 | Binary number of the enabled channel, 0 when none |
| valid | output | 1 | High when an enable is driven |
| fault | output | 1 | High when two or more selector lines are active |

## Verification
The assertions assume that `allow` and `mode` are synchronous to `clk`. They apply the gating and the lockout decision at the edge after each change, and they do not treat these two inputs as if they crossed a synchronizer. The assertions make no assumption about `sel_raw` beyond its being sampled at clock edges: the checker keeps its own delay line, which is cleared by reset exactly as the synchronizer is. The stimulus meets this by changing every input at the falling edge only, while `rst` is held for several cycles first. It then walks all sixteen switch patterns under each mode and allow setting, and finishes with random patterns.

// File: rtl/oen_guard_pkg.sv
package oen_guard_pkg;

   // Resolution policy selected by the mode pin.
   typedef enum logic {
      MODE_PRIORITY = 1'b0,
      MODE_LOCKOUT  = 1'b1
   } guard_mode_e;

endpackage

// File: rtl/oen_guard_sync.sv
// Multi-stage synchronizer for a bus of independent switch lines.
module oen_guard_sync #(
   parameter int WIDTH  = 4,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] d_in,
   output logic [WIDTH-1:0] d_out
);

   logic [WIDTH-1:0] stage_q [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (rst) stage_q[s] <= '0;
               else     stage_q[s] <= d_in;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (rst) stage_q[s] <= '0;
               else     stage_q[s] <= stage_q[s-1];
            end
         end
      end
   endgenerate

   assign d_out = stage_q[STAGES-1];

endmodule

// File: rtl/oen_guard_resolve.sv
// Combinational resolution: highest active line, any-active and overlap flags.
module oen_guard_resolve #(
   parameter int NUM_CH = 4,
   localparam int IDX_W = $clog2(NUM_CH)
) (
   input  logic [NUM_CH-1:0] lines,
   output logic [IDX_W-1:0]  top_idx,
   output logic              any_act,
   output logic              multi
);

   localparam int CNT_W = $clog2(NUM_CH + 1);

   logic [CNT_W-1:0] active_cnt;

   always_comb begin
      top_idx    = '0;
      active_cnt = '0;
      // Ascending scan: the last hit is the highest index, which wins.
      for (int i = 0; i < NUM_CH; i++) begin
         if (lines[i]) begin
            top_idx    = IDX_W'(i);
            active_cnt = active_cnt + CNT_W'(1);
         end
      end
   end

   assign any_act = |lines;
   assign multi   = (active_cnt >= CNT_W'(2));

endmodule

// File: rtl/oen_guard_decode.sv
// Binary index to one-hot enable decoder with a common gate.
module oen_guard_decode #(
   parameter int NUM_CH = 4,
   localparam int IDX_W = $clog2(NUM_CH)
) (
   input  logic [IDX_W-1:0]  idx,
   input  logic              gate,
   output logic [NUM_CH-1:0] onehot
);

   generate
      for (genvar g = 0; g < NUM_CH; g++) begin : g_dec
         assign onehot[g] = gate && (idx == IDX_W'(g));
      end
   endgenerate

endmodule

// File: rtl/oen_guard.sv
// One-hot output enable guard: top level.
module oen_guard
   import oen_guard_pkg::*;
#(
   parameter int NUM_CH      = 4,
   parameter int SYNC_STAGES = 2,
   localparam int IDX_W      = $clog2(NUM_CH)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [NUM_CH-1:0] sel_raw,
   input  logic              allow,
   input  logic              mode,
   output logic [NUM_CH-1:0] en_out,
   output logic [IDX_W-1:0]  chan_idx,
   output logic              valid,
   output logic              fault
);

   // Elaboration-time parameter checks.
   generate
      if (NUM_CH < 2 || (NUM_CH & (NUM_CH - 1)) != 0) begin : g_bad_ch
         $error("oen_guard: NUM_CH must be a power of two, at least 2");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("oen_guard: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [NUM_CH-1:0] sel_sync;
   logic [IDX_W-1:0]  top_idx;
   logic              any_act;
   logic              multi;
   logic              drive;
   logic [NUM_CH-1:0] en_next;
   guard_mode_e       mode_e;

   oen_guard_sync #(
      .WIDTH  (NUM_CH),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst   (rst),
      .d_in  (sel_raw),
      .d_out (sel_sync)
   );

   oen_guard_resolve #(
      .NUM_CH (NUM_CH)
   ) u_resolve (
      .lines   (sel_sync),
      .top_idx (top_idx),
      .any_act (any_act),
      .multi   (multi)
   );

   assign mode_e = guard_mode_e'(mode);

   // Drive an enable only when allowed, something is selected and
   // lockout mode has not seen an overlap.
   always_comb begin
      drive = allow && any_act;
      if (mode_e == MODE_LOCKOUT && multi) drive = 1'b0;
   end

   oen_guard_decode #(
      .NUM_CH (NUM_CH)
   ) u_decode (
      .idx    (top_idx),
      .gate   (drive),
      .onehot (en_next)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         en_out   <= '0;
         chan_idx <= '0;
         valid    <= 1'b0;
         fault    <= 1'b0;
      end else begin
         en_out   <= en_next;
         chan_idx <= drive ? top_idx : '0;
         valid    <= drive;
         fault    <= multi;
      end
   end

endmodule

// File: rtl/oen_guard_chk.sv
// Property checker for oen_guard, attached by bind.
module oen_guard_chk #(
   parameter int NUM_CH      = 4,
   parameter int SYNC_STAGES = 2,
   localparam int IDX_W      = $clog2(NUM_CH)
) (
   input logic              clk,
   input logic              rst,
   input logic [NUM_CH-1:0] sel_raw,
   input logic              allow,
   input logic              mode,
   input logic [NUM_CH-1:0] en_out,
   input logic [IDX_W-1:0]  chan_idx,
   input logic              valid,
   input logic              fault
);

   // Independent delay line of the raw inputs, cleared like the synchronizer.
   logic [NUM_CH-1:0] hist [SYNC_STAGES+1];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i <= SYNC_STAGES; i++) hist[i] <= '0;
      end else begin
         hist[0] <= sel_raw;
         for (int i = 1; i <= SYNC_STAGES; i++) hist[i] <= hist[i-1];
      end
   end

   AST_ONE_HOT_EN: assert property (@(posedge clk) disable iff (rst)
      $onehot0(en_out)); // R2

   AST_VALID_MATCH: assert property (@(posedge clk) disable iff (rst)
      valid == (en_out != '0)); // R10

   AST_IDX_POINTS: assert property (@(posedge clk) disable iff (rst)
      valid |-> en_out[chan_idx]); // R10

   AST_ALLOW_GATE: assert property (@(posedge clk) disable iff (rst)
      !allow |=> (en_out == '0 && !valid)); // R7

   AST_FAULT_TRACK: assert property (@(posedge clk) disable iff (rst)
      fault == ($countones(hist[SYNC_STAGES]) >= 2)); // R6

   AST_LOCKOUT_DROP: assert property (@(posedge clk) disable iff (rst)
      (mode && $countones(hist[SYNC_STAGES-1]) >= 2) |=> (en_out == '0)); // R5

endmodule

bind oen_guard oen_guard_chk #(
   .NUM_CH      (NUM_CH),
   .SYNC_STAGES (SYNC_STAGES)
) u_chk (
   .clk      (clk),
   .rst      (rst),
   .sel_raw  (sel_raw),
   .allow    (allow),
   .mode     (mode),
   .en_out   (en_out),
   .chan_idx (chan_idx),
   .valid    (valid),
   .fault    (fault)
);

// File: tb/oen_guard_test.sv
`timescale 1ns/1ps
module oen_guard_test;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [3:0] sel_raw = '0;
   logic       allow = 1'b0;
   logic       mode = 1'b0;
   logic [3:0] en_out;
   logic [1:0] chan_idx;
   logic       valid;
   logic       fault;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #2 clk = ~clk;   // 250 MHz

   oen_guard uut (
      .clk(clk), .rst(rst), .sel_raw(sel_raw), .allow(allow), .mode(mode),
      .en_out(en_out), .chan_idx(chan_idx), .valid(valid), .fault(fault)
   );

   // Reference model: a queue holds the raw inputs still inside the synchronizer.
   logic [3:0] pipe[$];
   logic [3:0] exp_en = '0;
   int         exp_idx = 0;
   bit         exp_valid = 0;
   bit         exp_fault = 0;
   string      exp_tag = "R1";

   always @(posedge clk) begin
      if (rst) begin
         pipe = {4'b0000, 4'b0000};
         exp_en = '0; exp_idx = 0; exp_valid = 0; exp_fault = 0;
         exp_tag = "R1";
      end else begin
         logic [3:0] seen;
         int cnt, hi;
         seen = pipe.pop_front();
         pipe.push_back(sel_raw);
         cnt = 0; hi = -1;
         for (int i = 0; i < 4; i++) if (seen[i]) begin cnt++; hi = i; end
         exp_fault = (cnt >= 2);
         if (!allow) begin
            exp_tag = "R7"; exp_en = '0; exp_idx = 0; exp_valid = 0;
         end else if (cnt == 0) begin
            exp_tag = "R8"; exp_en = '0; exp_idx = 0; exp_valid = 0;
         end else if (mode && cnt >= 2) begin
            exp_tag = "R5"; exp_en = '0; exp_idx = 0; exp_valid = 0;
         end else begin
            exp_tag = mode ? "R4" : "R3";
            exp_en = 4'b0001 << hi; exp_idx = hi; exp_valid = 1;
         end
      end
   end

   task automatic check(input bit ok, input string tag, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
      end
   endtask

   // Compare everything on every clock, away from the active edge.
   always @(negedge clk) begin
      if (!done) begin
         check(en_out == exp_en && chan_idx == exp_idx[1:0] && valid == exp_valid,
               exp_tag, "en/idx/valid", {en_out, 2'b00, chan_idx, 3'b000, valid},
               {exp_en, 2'b00, exp_idx[1:0], 3'b000, exp_valid});
         check(fault == exp_fault, rst ? "R1" : "R6", "fault", fault, exp_fault);
         check($countones(en_out) <= 1, "R2", "onehot", en_out, 0);
         check(valid == (en_out != 0) && (!valid || en_out[chan_idx]), "R10",
               "consistency", {en_out, 3'b000, valid}, 0);
      end
   end

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      step(4);
      check(en_out == 0 && valid == 0 && fault == 0 && chan_idx == 0, "R1",
            "reset state", {en_out, valid, fault}, 0);
      rst = 1'b0;
      // Exhaustive sweep of patterns under each mode and allow setting.
      for (int m = 0; m < 2; m++) begin
         for (int a = 0; a < 2; a++) begin
            for (int p = 0; p < 16; p++) begin
               mode = m[0]; allow = a[0]; sel_raw = p[3:0];
               step(4);
            end
         end
      end
      // Latency: raw change appears at the third rising edge (R9).
      mode = 1'b0; allow = 1'b1; sel_raw = 4'b0000;
      step(5);
      sel_raw = 4'b0010;
      step(2);
      check(en_out == 4'b0000, "R9", "not yet changed", en_out, 0);
      step(1);
      check(en_out == 4'b0010, "R9", "changed on third edge", en_out, 4'b0010);
      allow = 1'b0;
      step(1);
      check(en_out == 4'b0000, "R9", "allow next edge", en_out, 0);
      allow = 1'b1;
      sel_raw = 4'b0110;
      step(4);
      mode = 1'b1;
      step(1);
      check(en_out == 4'b0000 && fault, "R9", "mode next edge", {en_out, fault}, 5'b00001);
      // Random patterns.
      for (int i = 0; i < 3000; i++) begin
         sel_raw = 4'($urandom);
         if ($urandom_range(0, 7) == 0) allow = ~allow;
         if ($urandom_range(0, 15) == 0) mode = ~mode;
         step(1);
      end
      // Mid-run reset (R1).
      sel_raw = 4'b1000; allow = 1'b1; mode = 1'b0;
      step(5);
      rst = 1'b1;
      step(1);
      check(en_out == 0 && valid == 0 && chan_idx == 0, "R1", "reset clears",
            {en_out, valid}, 0);
      rst = 1'b0;
      step(6);
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++; errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule